// File: doc/BRIEF.md
# Iterative Euclidean Distance Pixel Cell

This block is the processing element for one pixel of an iterative Euclidean distance transform array. Every pixel of the image has one cell, and the cells are wired to their eight nearest neighbours. Each cell holds a row offset and a column offset to the nearest background pixel found so far. It also holds a done flag and a small signed score, delta = k² + k − (Δr² + Δc²), which replaces the squared distance and stays small. The squared distance follows from the offsets and can be recovered at readout.

On every iteration strobe, all cells in the array step together with the same iteration number k. A cell that is not yet done forms one candidate from each done neighbour. It adjusts the neighbour's offsets by one when the neighbour is in a different row or column, and lowers the neighbour's score by the matching odd penalties. It then keeps the best candidate if that candidate is not negative. A cell that is already done only advances its score by 2k. A synchronous reset loads the pixel's class: a background pixel starts done with zero offsets, and a foreground pixel starts not done.

Top module: `edt_cell`

## Requirements
- R1: While `rst` is high at a clock edge, the cell loads offsets 0, delta 0 and done = `init_bg` (1 marks a background pixel), whatever the other inputs are.
- R2: When `rst` is low and `step` is low at a clock edge, all outputs keep their values.
- R3: On a step edge, a cell that is already done adds 2·k to its delta, keeps both offsets and stays done.
- R4: Neighbour index i occupies slot i of each neighbour bus. Indices 0..7 sit at (row, column) displacements (−1,−1), (−1,0), (−1,+1), (0,−1), (0,+1), (+1,−1), (+1,0), (+1,+1). The candidate score of neighbour i is its delta + 2k − PR − PC. PR is 0 for the same-row neighbours 3 and 4, and 2·Δr_i + 1 otherwise. PC is 0 for the same-column neighbours 1 and 6, and 2·Δc_i + 1 otherwise.
- R5: The candidate row offset is Δr_i for neighbours 3 and 4, and Δr_i + 1 otherwise. The candidate column offset is Δc_i for neighbours 1 and 6, and Δc_i + 1 otherwise.
- R6: Only neighbours whose done bit is 1 produce candidates. A not-done neighbour never changes the cell, whatever values it carries.
- R7: On a step edge, a not-done cell takes the offsets and score of the largest candidate and sets done, provided that score is 0 or more. If the largest score is negative, or if no candidate exists, the cell stays unchanged and not done.
- R8: When candidates tie for the largest score, the one with the lowest neighbour index wins.
- R9: Reference points: a background neighbour above gives (1,0) with delta 1 at k=1. A neighbour at (1,0) with delta 1, seen diagonally, gives (2,1) with delta 1 at k=2. A neighbour at (1,1) with delta 4, seen diagonally, gives (2,2) with delta 4 at k=3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset that loads the pixel class |
| init_bg | input | 1 | Pixel class loaded at reset, 1 = background |
| step | input | 1 | Iteration strobe shared by the whole array |
| k_in | input | K_W | Iteration number of the current step |
| nb_dr | input | 8·OFS_W | Row offsets of the neighbours, slot i = neighbour i |
| nb_dc | input | 8·OFS_W | Column offsets of the neighbours |
| nb_dlt | input | 8·DLT_W | Signed delta scores of the neighbours |
| nb_done | input | 8 | Done flags of the neighbours |
| dr_o | output | OFS_W | Own row offset |
| dc_o | output | OFS_W | Own column offset |
| dlt_o | output | DLT_W | Own signed delta score |
| done_o | output | 1 | Own done flag |

## Verification
The hardest case to reach is an exact tie between candidates that carry different offsets. Two neighbours can reach the same score only through matching penalties on opposite axes, so random values almost never produce a tie that shows which neighbour won. The stimulus therefore often copies the upper neighbour's state, with rows and columns swapped, into the left neighbour, and it also includes directed ties. The bench also builds cases with a score of exactly zero and cases with a negative best score, so that the acceptance threshold is tested on both sides.

// File: rtl/edt_cell_pkg.sv
package edt_cell_pkg;

    // number of neighbours around a pixel
    localparam int NB = 8;

    // neighbours 3 and 4 share the pixel's row
    function automatic bit nb_same_row(input int idx);
        return (idx == 3) || (idx == 4);
    endfunction

    // neighbours 1 and 6 share the pixel's column
    function automatic bit nb_same_col(input int idx);
        return (idx == 1) || (idx == 6);
    endfunction

endpackage

// File: rtl/edt_nbr_cand.sv
module edt_nbr_cand #(
    parameter int OFS_W    = 5,
    parameter int DLT_W    = 12,
    parameter int K_W      = 4,
    parameter bit SAME_ROW = 1'b0,
    parameter bit SAME_COL = 1'b0
) (
    input  logic [K_W-1:0]          k_i,
    input  logic [OFS_W-1:0]        dr_i,
    input  logic [OFS_W-1:0]        dc_i,
    input  logic signed [DLT_W-1:0] dlt_i,
    input  logic                    done_i,
    output logic                    c_valid,
    output logic [OFS_W-1:0]        c_dr,
    output logic [OFS_W-1:0]        c_dc,
    output logic signed [DLT_W-1:0] c_dlt
);

    logic signed [DLT_W-1:0] two_k;
    logic signed [DLT_W-1:0] pen_r;
    logic signed [DLT_W-1:0] pen_c;

    assign two_k = DLT_W'({k_i, 1'b0});

    // row penalty and row offset: none for a neighbour in the same row
    if (SAME_ROW) begin : g_row_same
        assign pen_r = '0;
        assign c_dr  = dr_i;
    end else begin : g_row_diff
        assign pen_r = DLT_W'({dr_i, 1'b1});
        assign c_dr  = dr_i + OFS_W'(1);
    end

    // column penalty and column offset
    if (SAME_COL) begin : g_col_same
        assign pen_c = '0;
        assign c_dc  = dc_i;
    end else begin : g_col_diff
        assign pen_c = DLT_W'({dc_i, 1'b1});
        assign c_dc  = dc_i + OFS_W'(1);
    end

    assign c_valid = done_i;
    assign c_dlt   = dlt_i + two_k - pen_r - pen_c;

endmodule

// File: rtl/edt_best_pick.sv
module edt_best_pick
    import edt_cell_pkg::*;
#(
    parameter int OFS_W = 5,
    parameter int DLT_W = 12
) (
    input  logic [NB-1:0]          cv_i,
    input  logic [NB*OFS_W-1:0]    cdr_i,
    input  logic [NB*OFS_W-1:0]    cdc_i,
    input  logic [NB*DLT_W-1:0]    cdlt_i,
    output logic                   best_v,
    output logic [OFS_W-1:0]       best_dr,
    output logic [OFS_W-1:0]       best_dc,
    output logic signed [DLT_W-1:0] best_dlt
);

    // linear scan in index order; a strict compare keeps the lowest index on ties
    always_comb begin
        best_v   = 1'b0;
        best_dr  = '0;
        best_dc  = '0;
        best_dlt = '0;
        for (int i = 0; i < NB; i++) begin
            if (cv_i[i] && (!best_v || ($signed(cdlt_i[i*DLT_W +: DLT_W]) > best_dlt))) begin
                best_v   = 1'b1;
                best_dr  = cdr_i[i*OFS_W +: OFS_W];
                best_dc  = cdc_i[i*OFS_W +: OFS_W];
                best_dlt = $signed(cdlt_i[i*DLT_W +: DLT_W]);
            end
        end
    end

endmodule

// File: rtl/edt_cell.sv
module edt_cell
    import edt_cell_pkg::*;
#(
    parameter int OFS_W = 5,
    parameter int DLT_W = 12,
    parameter int K_W   = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    init_bg,
    input  logic                    step,
    input  logic [K_W-1:0]          k_in,
    input  logic [NB*OFS_W-1:0]     nb_dr,
    input  logic [NB*OFS_W-1:0]     nb_dc,
    input  logic [NB*DLT_W-1:0]     nb_dlt,
    input  logic [NB-1:0]           nb_done,
    output logic [OFS_W-1:0]        dr_o,
    output logic [OFS_W-1:0]        dc_o,
    output logic signed [DLT_W-1:0] dlt_o,
    output logic                    done_o
);

    typedef struct packed {
        logic                    done;
        logic [OFS_W-1:0]        dr;
        logic [OFS_W-1:0]        dc;
        logic signed [DLT_W-1:0] dlt;
    } cell_st_t;

    cell_st_t st_d, st_q;

    logic [NB-1:0]           cv;
    logic [NB*OFS_W-1:0]     cdr;
    logic [NB*OFS_W-1:0]     cdc;
    logic [NB*DLT_W-1:0]     cdlt;
    logic                    best_v;
    logic [OFS_W-1:0]        best_dr;
    logic [OFS_W-1:0]        best_dc;
    logic signed [DLT_W-1:0] best_dlt;
    logic signed [DLT_W-1:0] two_k;

    for (genvar g = 0; g < NB; g++) begin : g_nb
        logic signed [DLT_W-1:0] cand_dlt;
        edt_nbr_cand #(
            .OFS_W   (OFS_W),
            .DLT_W   (DLT_W),
            .K_W     (K_W),
            .SAME_ROW(nb_same_row(g)),
            .SAME_COL(nb_same_col(g))
        ) cand_i (
            .k_i    (k_in),
            .dr_i   (nb_dr[g*OFS_W +: OFS_W]),
            .dc_i   (nb_dc[g*OFS_W +: OFS_W]),
            .dlt_i  ($signed(nb_dlt[g*DLT_W +: DLT_W])),
            .done_i (nb_done[g]),
            .c_valid(cv[g]),
            .c_dr   (cdr[g*OFS_W +: OFS_W]),
            .c_dc   (cdc[g*OFS_W +: OFS_W]),
            .c_dlt  (cand_dlt)
        );
        assign cdlt[g*DLT_W +: DLT_W] = cand_dlt;
    end

    edt_best_pick #(
        .OFS_W(OFS_W),
        .DLT_W(DLT_W)
    ) pick_i (
        .cv_i    (cv),
        .cdr_i   (cdr),
        .cdc_i   (cdc),
        .cdlt_i  (cdlt),
        .best_v  (best_v),
        .best_dr (best_dr),
        .best_dc (best_dc),
        .best_dlt(best_dlt)
    );

    assign two_k = DLT_W'({k_in, 1'b0});

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.done = init_bg;
            st_d.dr   = '0;
            st_d.dc   = '0;
            st_d.dlt  = '0;
        end else if (step) begin
            if (st_q.done) begin
                st_d.dlt = st_q.dlt + two_k;
            end else if (best_v && !best_dlt[DLT_W-1]) begin
                st_d.done = 1'b1;
                st_d.dr   = best_dr;
                st_d.dc   = best_dc;
                st_d.dlt  = best_dlt;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign dr_o   = st_q.dr;
    assign dc_o   = st_q.dc;
    assign dlt_o  = st_q.dlt;
    assign done_o = st_q.done;

endmodule

// File: rtl/edt_cell_chk.sv
module edt_cell_chk #(
    parameter int OFS_W = 5,
    parameter int DLT_W = 12,
    parameter int K_W   = 4
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    init_bg,
    input logic                    step,
    input logic [K_W-1:0]          k_in,
    input logic [7:0]              nb_done,
    input logic [OFS_W-1:0]        dr_o,
    input logic [OFS_W-1:0]        dc_o,
    input logic signed [DLT_W-1:0] dlt_o,
    input logic                    done_o
);

    logic signed [DLT_W-1:0] dbl_k;
    assign dbl_k = DLT_W'({k_in, 1'b0});

    AST_RESET_LOAD: assert property (@(posedge clk)
        rst |=> (dr_o == '0 && dc_o == '0 && dlt_o == '0 && done_o == $past(init_bg))); // R1

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !step |=> ($stable(dr_o) && $stable(dc_o) && $stable(dlt_o) && $stable(done_o))); // R2

    AST_DONE_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (step && done_o) |=> (done_o && $stable(dr_o) && $stable(dc_o)
                              && dlt_o == $past(dlt_o) + $past(dbl_k))); // R3

    AST_NO_SOURCE: assert property (@(posedge clk) disable iff (rst)
        (step && !done_o && nb_done == '0) |=> !done_o); // R6

    AST_ACCEPT_NONNEG: assert property (@(posedge clk) disable iff (rst)
        (step && !done_o) |=> (!done_o || dlt_o >= 0)); // R7

endmodule

bind edt_cell edt_cell_chk #(
    .OFS_W(OFS_W),
    .DLT_W(DLT_W),
    .K_W  (K_W)
) chk_i (
    .clk    (clk),
    .rst    (rst),
    .init_bg(init_bg),
    .step   (step),
    .k_in   (k_in),
    .nb_done(nb_done),
    .dr_o   (dr_o),
    .dc_o   (dc_o),
    .dlt_o  (dlt_o),
    .done_o (done_o)
);

// File: tb/edt_cell_tb_top.sv
module edt_cell_tb_top;

    localparam int OFS_W = 5;
    localparam int DLT_W = 12;
    localparam int K_W   = 4;

    typedef struct {
        int dr;
        int dc;
        int dlt;
        bit done;
    } mst_t;

    logic                    clk = 1'b0;
    logic                    rst;
    logic                    init_bg;
    logic                    step;
    logic [K_W-1:0]          k_in;
    logic [8*OFS_W-1:0]      nb_dr;
    logic [8*OFS_W-1:0]      nb_dc;
    logic [8*DLT_W-1:0]      nb_dlt;
    logic [7:0]              nb_done;
    logic [OFS_W-1:0]        dr_o;
    logic [OFS_W-1:0]        dc_o;
    logic signed [DLT_W-1:0] dlt_o;
    logic                    done_o;

    int ndr[8];
    int ndc[8];
    int ndl[8];
    bit ndn[8];
    int kk;
    bit stp;
    bit rstb;
    bit ibg;
    mst_t ms;
    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    edt_cell #(.OFS_W(OFS_W), .DLT_W(DLT_W), .K_W(K_W)) dut_i (
        .clk(clk), .rst(rst), .init_bg(init_bg), .step(step), .k_in(k_in),
        .nb_dr(nb_dr), .nb_dc(nb_dc), .nb_dlt(nb_dlt), .nb_done(nb_done),
        .dr_o(dr_o), .dc_o(dc_o), .dlt_o(dlt_o), .done_o(done_o)
    );

    // expected next state from the requirements
    function automatic mst_t model(input mst_t s);
        mst_t n = s;
        int best = 0;
        bit have = 1'b0;
        int bdr = 0;
        int bdc = 0;
        if (rstb) begin
            n.dr = 0; n.dc = 0; n.dlt = 0; n.done = ibg;
            return n;
        end
        if (!stp) return n;
        if (s.done) begin
            n.dlt = s.dlt + 2 * kk;
            return n;
        end
        for (int i = 0; i < 8; i++) begin
            if (ndn[i]) begin
                bit sr = (i == 3 || i == 4);
                bit sc = (i == 1 || i == 6);
                int c = ndl[i] + 2 * kk - (sr ? 0 : 2 * ndr[i] + 1) - (sc ? 0 : 2 * ndc[i] + 1);
                if (!have || c > best) begin
                    have = 1'b1; best = c;
                    bdr = sr ? ndr[i] : ndr[i] + 1;
                    bdc = sc ? ndc[i] : ndc[i] + 1;
                end
            end
        end
        if (have && best >= 0) begin
            n.dr = bdr; n.dc = bdc; n.dlt = best; n.done = 1'b1;
        end
        return n;
    endfunction

    task automatic drive();
        rst = rstb; init_bg = ibg; step = stp; k_in = K_W'(kk);
        for (int i = 0; i < 8; i++) begin
            nb_dr[i*OFS_W +: OFS_W]  = OFS_W'(ndr[i]);
            nb_dc[i*OFS_W +: OFS_W]  = OFS_W'(ndc[i]);
            nb_dlt[i*DLT_W +: DLT_W] = DLT_W'(ndl[i]);
            nb_done[i]               = ndn[i];
        end
    endtask

    task automatic chk(input string tag, input mst_t e);
        n_chk++;
        if (int'(dr_o) != e.dr || int'(dc_o) != e.dc || int'(dlt_o) != e.dlt || done_o != e.done) begin
            n_bad++;
            $display("FAIL %s got dr=%0d dc=%0d dlt=%0d done=%0d exp dr=%0d dc=%0d dlt=%0d done=%0d",
                     tag, dr_o, dc_o, dlt_o, done_o, e.dr, e.dc, e.dlt, e.done);
        end
    endtask

    // one clock: drive now, compare against the model at the next falling edge
    task automatic cycle(input string tag);
        mst_t e;
        e = model(ms);
        drive();
        @(negedge clk);
        chk(tag, e);
        ms = e;
    endtask

    task automatic lit(input string tag, input int dr, input int dc, input int dl, input bit dn);
        mst_t e;
        e.dr = dr; e.dc = dc; e.dlt = dl; e.done = dn;
        chk(tag, e);
    endtask

    task automatic clear_nb();
        for (int i = 0; i < 8; i++) begin
            ndr[i] = 0; ndc[i] = 0; ndl[i] = 0; ndn[i] = 1'b0;
        end
    endtask

    task automatic do_reset(input bit bg);
        rstb = 1'b1; ibg = bg; stp = 1'b1;
        cycle("R1");
        rstb = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        ms.dr = 0; ms.dc = 0; ms.dlt = 0; ms.done = 1'b0;
        clear_nb(); kk = 1; stp = 1'b0; rstb = 1'b1; ibg = 1'b0;
        drive();
        @(negedge clk);

        // R1: reset loads the pixel class
        do_reset(1'b1); lit("R1", 0, 0, 0, 1'b1);
        do_reset(1'b0); lit("R1", 0, 0, 0, 1'b0);

        // R2: no strobe, no change even with a good neighbour present
        clear_nb(); ndn[1] = 1'b1; stp = 1'b0; kk = 1;
        cycle("R2"); lit("R2", 0, 0, 0, 1'b0);

        // R9 / R4 / R5: background above at k=1
        stp = 1'b1; cycle("R9"); lit("R9", 1, 0, 1, 1'b1);
        // R3: done cell advances by 2k
        kk = 3; cycle("R3"); lit("R3", 1, 0, 7, 1'b1);

        // R9: diagonal (1,0) delta 1 at k=2
        do_reset(1'b0); clear_nb(); ndn[0] = 1'b1; ndr[0] = 1; ndl[0] = 1; kk = 2;
        cycle("R9"); lit("R9", 2, 1, 1, 1'b1);
        // R9: diagonal (1,1) delta 4 at k=3
        do_reset(1'b0); clear_nb(); ndn[7] = 1'b1; ndr[7] = 1; ndc[7] = 1; ndl[7] = 4; kk = 3;
        cycle("R9"); lit("R9", 2, 2, 4, 1'b1);

        // R6: only a not-done neighbour with a large score
        do_reset(1'b0); clear_nb(); ndl[4] = 100; kk = 2;
        cycle("R6"); lit("R6", 0, 0, 0, 1'b0);
        // R6: the done low-score neighbour wins over a not-done high one
        ndn[0] = 1'b1; cycle("R6"); lit("R6", 1, 1, 2, 1'b1);

        // R7: negative best score rejected
        do_reset(1'b0); clear_nb(); ndn[0] = 1'b1; ndl[0] = -10; kk = 1;
        cycle("R7"); lit("R7", 0, 0, 0, 1'b0);
        // R7: a score of exactly zero is accepted
        ndl[0] = 0; cycle("R7"); lit("R7", 1, 1, 0, 1'b1);

        // R8: neighbours 1 and 3 tie with different offsets, 1 wins
        do_reset(1'b0); clear_nb(); kk = 2;
        ndn[1] = 1'b1; ndr[1] = 0; ndc[1] = 2; ndl[1] = 5;
        ndn[3] = 1'b1; ndr[3] = 2; ndc[3] = 0; ndl[3] = 5;
        cycle("R8"); lit("R8", 1, 2, 8, 1'b1);
        // R8: neighbours 4 and 6 tie, 4 wins
        do_reset(1'b0); clear_nb(); kk = 1;
        ndn[6] = 1'b1; ndr[6] = 1; ndc[6] = 3; ndl[6] = 6;
        ndn[4] = 1'b1; ndr[4] = 3; ndc[4] = 1; ndl[4] = 6;
        cycle("R8"); lit("R8", 3, 2, 5, 1'b1);

        // random phase checked against the model (R4, R5, R7, R8 among others)
        for (int n = 0; n < 4000; n++) begin
            string tag;
            rstb = ($urandom_range(0, 19) == 0);
            ibg  = $urandom_range(0, 3) == 0;
            stp  = $urandom_range(0, 3) != 0;
            kk   = $urandom_range(1, 7);
            for (int i = 0; i < 8; i++) begin
                ndn[i] = $urandom_range(0, 2) == 0;
                ndr[i] = $urandom_range(0, 6);
                ndc[i] = $urandom_range(0, 6);
                ndl[i] = int'($urandom_range(0, 80)) - 30;
            end
            if ($urandom_range(0, 3) == 0) begin
                ndn[3] = ndn[1]; ndr[3] = ndc[1]; ndc[3] = ndr[1]; ndl[3] = ndl[1];
            end
            if (rstb) tag = "R1";
            else if (!stp) tag = "R2";
            else if (ms.done) tag = "R3";
            else tag = "R7";
            cycle(tag);
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule